// File: doc/BRIEF.md
# Stipple Span Painter

This block fills one horizontal run of pixels in an 8-bit-per-pixel frame buffer, using a 1-bit stipple bitmap as the pattern. The span is given by a byte address and a pixel count. The stipple arrives in 32-bit beats over a valid/ready stream. Bit 0 of the first beat belongs to the first pixel of the span. Bit j of beat b belongs to pixel start + 32*b + j.

The block covers the span one 32-bit destination word at a time. Each write carries per-lane byte enables, and four stipple bits map to the four byte lanes of a word. Both edges of the span are aligned to word boundaries. At the start, the pattern is shifted up by the low two address bits. At the end, bits past the last pixel are masked off.

In transparent mode, only pixels whose bit is 1 are written, and each is written with the foreground value. The enables are limited to a small set of store shapes, so a group may need two writes. The span ends as soon as no set bit remains. In opaque mode, every pixel of the span is written: foreground where the bit is 1 and background where it is 0.

Top module: `stip_span_painter`

## Requirements
- R1: After reset, `span_ready` is 1 and `wr_valid`, `span_done` and `stip_ready` are 0.
- R2: In transparent mode (`span_opaque`=0), each span pixel whose stipple bit is 1 becomes `fg_pix`. Every pixel whose bit is 0 keeps its old value.
- R3: In opaque mode (`span_opaque`=1), each span pixel becomes `fg_pix` when its bit is 1 and `bg_pix` when its bit is 0. Byte lane i of the word at `wr_addr` is byte address 4*`wr_addr`+i, and `wr_be` bit i enables lane i.
- R4: Pixels below the start address are never changed. The first word written is at `span_addr` >> 2.
- R5: Pixels at or beyond `span_addr` + `span_width` are never changed.
- R6: In transparent mode, each written `wr_be` is one of 0001, 0010, 0100, 1000, 0011, 1100, 0111, 1110 or 1111. A 4-bit group costs no write if it is zero, one write if its pattern is in that set, and two writes otherwise.
- R7: In opaque mode, exactly one write is made per destination word the span touches. The first partial word enables only the lanes at or above the start offset. The last partial word enables only the lanes up to the final pixel.
- R8: A span that lies inside a single word is painted with one combined enable mask in opaque mode. In transparent mode it costs at most two writes.
- R9: In transparent mode, `span_done` follows the write of the last nonzero group without visiting later words. An all-zero pattern produces no write at all.
- R10: Every transparent-mode write carries `fg_pix` in all four lanes of `wr_data`.
- R11: `span_done` is a one-cycle pulse, given once per span. `span_ready` is 0 from acceptance until `span_done`, and a `span_start` seen while busy is ignored.
- R12: A span of width 0 gives `span_done` in the cycle after acceptance, with no write and no beat requested.
- R13: Exactly ceil(`span_width`/32) stipple beats are taken per span. `stip_ready` is never 1 while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| span_start | input | 1 | Request to paint a span, taken when `span_ready` is 1 |
| span_addr | input | ADDR_W | Byte address of the first pixel |
| span_width | input | WIDTH_W | Number of pixels in the span |
| span_opaque | input | 1 | 1 selects opaque mode, 0 selects transparent mode |
| fg_pix | input | PIX_W | Foreground pixel value |
| bg_pix | input | PIX_W | Background pixel value |
| span_ready | output | 1 | Idle and able to take a span |
| stip_valid | input | 1 | A stipple beat is offered |
| stip_data | input | BEAT_W | Stipple beat, bit 0 first |
| stip_ready | output | 1 | The offered beat is taken at this edge |
| wr_valid | output | 1 | A write is presented this cycle |
| wr_addr | output | ADDR_W-2 | Word address of the write |
| wr_be | output | 4 | Byte-lane enables |
| wr_data | output | 4*PIX_W | Write data, lane i in bits 8i+7..8i |
| span_done | output | 1 | End-of-span pulse |

## Verification
The painter is driven with a table of spans in both modes, at all four start alignments and across one-word, two-beat and tail-only widths. The bench replays the writes into a model of memory and compares the result byte for byte. This separates errors at the left edge (pixels below the start) from errors at the right edge (pixels past the end). It also exposes lane-order errors, because bit 0 must land at the lowest address.

Several patterns are chosen because each demands two writes per group (1001, 0110, 1011). These tell a correct split into legal stores from a single illegal store. Counting writes separates them from redundant extra stores.

An all-zero pattern and a pattern with a single leading bit test the early finish. Zero width, a start request during a busy span, and a reset in mid-span test the handshake.

// File: rtl/stip_pkg.sv
package stip_pkg;

  localparam int LANES = 4;

  // Enable shapes that one memory write may carry: single byte, aligned
  // half, full word, or a contiguous run anchored on lane 0 or lane 3.
  function automatic logic is_single_store(input logic [3:0] m);
    case (m)
      4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b1100, 4'b0111, 4'b1110, 4'b1111: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // First of at most two writes covering a lane pattern.
  function automatic logic [3:0] first_store(input logic [3:0] m);
    if (is_single_store(m)) return m;
    case (m)
      4'b0101, 4'b1001, 4'b1101: return 4'b0001;
      4'b1010, 4'b0110:          return 4'b0010;
      4'b1011:                   return 4'b0011;
      default:                   return m;
    endcase
  endfunction

endpackage

// File: rtl/stip_bitbuf.sv
module stip_bitbuf #(
  parameter int BEAT_W = 32,
  parameter int BUF_W  = 40,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [1:0]        init_cnt,
  input  logic              load,
  input  logic [BEAT_W-1:0] load_data,
  input  logic              shift,
  output logic [BUF_W-1:0]  bits,
  output logic [CNT_W-1:0]  cnt
);
  localparam int GROUP = stip_pkg::LANES;

  // Leading zeros equal to the start offset align the pattern to a word.
  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
      cnt  <= '0;
    end else if (clear) begin
      bits <= '0;
      cnt  <= CNT_W'(init_cnt);
    end else if (load) begin
      bits <= bits | (BUF_W'(load_data) << cnt);
      cnt  <= cnt + CNT_W'(BEAT_W);
    end else if (shift) begin
      bits <= bits >> GROUP;
      cnt  <= cnt - CNT_W'(GROUP);
    end
  end
endmodule

// File: rtl/stip_lane_mask.sv
module stip_lane_mask #(
  parameter int REM_W = 13
) (
  input  logic [REM_W-1:0] rem,
  input  logic [1:0]       lead,
  input  logic             first,
  output logic [3:0]       mask
);
  logic [3:0] tail, head;

  always_comb begin
    if (rem >= REM_W'(stip_pkg::LANES)) tail = 4'hF;
    else                                tail = (4'd1 << rem[1:0]) - 4'd1;
    head = first ? (4'hF << lead) : 4'hF;
    mask = tail & head;
  end
endmodule

// File: rtl/stip_live_scan.sv
module stip_live_scan #(
  parameter int BUF_W = 40,
  parameter int REM_W = 13
) (
  input  logic [BUF_W-1:0] bits,
  input  logic [REM_W-1:0] rem,
  output logic             any_live,
  output logic             later_live
);
  localparam int GROUP = stip_pkg::LANES;

  logic [BUF_W-1:0] keep;

  for (genvar i = 0; i < BUF_W; i++) begin : g_keep
    assign keep[i] = (REM_W'(i) < rem);
  end

  assign any_live   = |(bits & keep);
  assign later_live = |(bits & keep & ~BUF_W'((1 << GROUP) - 1));
endmodule

// File: rtl/stip_span_painter.sv
module stip_span_painter #(
  parameter int ADDR_W  = 16,
  parameter int WIDTH_W = 12,
  parameter int BEAT_W  = 32,
  parameter int PIX_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          span_start,
  input  logic [ADDR_W-1:0]             span_addr,
  input  logic [WIDTH_W-1:0]            span_width,
  input  logic                          span_opaque,
  input  logic [PIX_W-1:0]              fg_pix,
  input  logic [PIX_W-1:0]              bg_pix,
  output logic                          span_ready,
  input  logic                          stip_valid,
  input  logic [BEAT_W-1:0]             stip_data,
  output logic                          stip_ready,
  output logic                          wr_valid,
  output logic [ADDR_W-3:0]             wr_addr,
  output logic [3:0]                    wr_be,
  output logic [stip_pkg::LANES*PIX_W-1:0] wr_data,
  output logic                          span_done
);
  import stip_pkg::*;

  localparam int WORD_W  = LANES * PIX_W;
  localparam int WADDR_W = ADDR_W - 2;
  localparam int REM_W   = WIDTH_W + 1;
  localparam int BUF_W   = BEAT_W + 2 * LANES;
  localparam int CNT_W   = $clog2(BUF_W + 1);
  localparam int BEATS_W = WIDTH_W;
  localparam int BEAT_SH = $clog2(BEAT_W);

  logic               busy, opaque_q, first_q, pend_q, pend_last;
  logic [PIX_W-1:0]   fg_q, bg_q;
  logic [WADDR_W-1:0] word_ptr;
  logic [1:0]         lead_q;
  logic [REM_W-1:0]   rem;
  logic [BEATS_W-1:0] beats_left;
  logic [3:0]         pend_be;

  logic [BUF_W-1:0]   bits;
  logic [CNT_W-1:0]   cnt;
  logic [3:0]         lane_mask, group, first_be, second_be;
  logic               any_live, later_live;
  logic               need_load, proc, trans_stop, last_grp, accept;
  logic [REM_W-1:0]   rem_init, beats_sum;
  logic [BEATS_W-1:0] beats_init;
  logic [WORD_W-1:0]  opq_data;

  assign accept     = !busy && span_start;
  assign span_ready = !busy;
  assign rem_init   = REM_W'(span_width) + REM_W'(span_addr[1:0]);
  assign beats_sum  = REM_W'(span_width) + REM_W'(BEAT_W - 1);
  assign beats_init = BEATS_W'(beats_sum >> BEAT_SH);

  assign need_load  = busy && !pend_q && (cnt < CNT_W'(LANES)) && (beats_left != '0);
  assign stip_ready = need_load;
  assign proc       = busy && !pend_q && !need_load;
  assign trans_stop = !opaque_q && (beats_left == '0) && !any_live;
  assign last_grp   = (rem <= REM_W'(LANES)) || (!opaque_q && (beats_left == '0) && !later_live);

  assign group      = bits[3:0] & lane_mask;
  assign first_be   = first_store(group);
  assign second_be  = group & ~first_be;

  for (genvar l = 0; l < LANES; l++) begin : g_opq
    assign opq_data[l*PIX_W +: PIX_W] = bits[l] ? fg_q : bg_q;
  end

  stip_bitbuf #(.BEAT_W(BEAT_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) i_buf (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .init_cnt (span_addr[1:0]),
    .load     (need_load && stip_valid),
    .load_data(stip_data),
    .shift    (proc && !trans_stop),
    .bits     (bits),
    .cnt      (cnt)
  );

  stip_lane_mask #(.REM_W(REM_W)) i_mask (
    .rem  (rem),
    .lead (lead_q),
    .first(first_q),
    .mask (lane_mask)
  );

  stip_live_scan #(.BUF_W(BUF_W), .REM_W(REM_W)) i_scan (
    .bits      (bits),
    .rem       (rem),
    .any_live  (any_live),
    .later_live(later_live)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      opaque_q   <= 1'b0;
      first_q    <= 1'b0;
      pend_q     <= 1'b0;
      pend_last  <= 1'b0;
      pend_be    <= '0;
      fg_q       <= '0;
      bg_q       <= '0;
      word_ptr   <= '0;
      lead_q     <= '0;
      rem        <= '0;
      beats_left <= '0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_be      <= '0;
      wr_data    <= '0;
      span_done  <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      span_done <= 1'b0;
      if (!busy) begin
        if (span_start) begin
          opaque_q   <= span_opaque;
          fg_q       <= fg_pix;
          bg_q       <= bg_pix;
          word_ptr   <= span_addr[ADDR_W-1:2];
          lead_q     <= span_addr[1:0];
          rem        <= rem_init;
          beats_left <= beats_init;
          first_q    <= 1'b1;
          pend_q     <= 1'b0;
          if (span_width == '0) span_done <= 1'b1;
          else                  busy      <= 1'b1;
        end
      end else if (pend_q) begin
        wr_valid <= 1'b1;
        wr_be    <= pend_be;
        pend_q   <= 1'b0;
        if (pend_last) begin
          busy      <= 1'b0;
          span_done <= 1'b1;
        end
      end else if (need_load) begin
        if (stip_valid) beats_left <= beats_left - BEATS_W'(1);
      end else if (trans_stop) begin
        busy      <= 1'b0;
        span_done <= 1'b1;
      end else begin
        word_ptr <= word_ptr + WADDR_W'(1);
        rem      <= rem - REM_W'(LANES);
        first_q  <= 1'b0;
        wr_addr  <= word_ptr;
        if (opaque_q) begin
          wr_valid <= 1'b1;
          wr_be    <= lane_mask;
          wr_data  <= opq_data;
          if (last_grp) begin
            busy      <= 1'b0;
            span_done <= 1'b1;
          end
        end else begin
          wr_data <= {LANES{fg_q}};
          if (group != 4'b0000) begin
            wr_valid <= 1'b1;
            wr_be    <= first_be;
          end
          if (second_be != 4'b0000) begin
            pend_q    <= 1'b1;
            pend_be   <= second_be;
            pend_last <= last_grp;
          end else if (last_grp) begin
            busy      <= 1'b0;
            span_done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stip_span_painter_chk.sv
module stip_span_painter_chk #(
  parameter int WIDTH_W = 12,
  parameter int PIX_W   = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 span_start,
  input logic [WIDTH_W-1:0]   span_width,
  input logic                 span_opaque,
  input logic [PIX_W-1:0]     fg_pix,
  input logic                 span_ready,
  input logic                 stip_ready,
  input logic                 wr_valid,
  input logic [3:0]           wr_be,
  input logic [4*PIX_W-1:0]   wr_data,
  input logic                 span_done
);
  logic             mode_c;
  logic [PIX_W-1:0] fg_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_c <= 1'b0;
      fg_c   <= '0;
    end else if (span_start && span_ready) begin
      mode_c <= span_opaque;
      fg_c   <= fg_pix;
    end
  end

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    span_done |=> !span_done);

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (span_start && span_ready && span_width != '0) |=> !span_ready);

  a_r6_legal_store: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !mode_c) |-> stip_pkg::is_single_store(wr_be));

  a_r10_fg_lanes: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !mode_c) |-> (wr_data == {4{fg_c}}));

  a_r13_ready_only_busy: assert property (@(posedge clk) disable iff (rst)
    stip_ready |-> !span_ready);

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    (span_ready && !span_done) |-> !wr_valid);
endmodule

bind stip_span_painter stip_span_painter_chk #(.WIDTH_W(WIDTH_W), .PIX_W(PIX_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .span_start (span_start),
  .span_width (span_width),
  .span_opaque(span_opaque),
  .fg_pix     (fg_pix),
  .span_ready (span_ready),
  .stip_ready (stip_ready),
  .wr_valid   (wr_valid),
  .wr_be      (wr_be),
  .wr_data    (wr_data),
  .span_done  (span_done)
);

// File: tb/test_stip_span_painter.sv
module test_stip_span_painter;
  localparam int ADDR_W = 16, WIDTH_W = 12, BEAT_W = 32, PIX_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic               span_start = 1'b0;
  logic [ADDR_W-1:0]  span_addr = '0;
  logic [WIDTH_W-1:0] span_width = '0;
  logic               span_opaque = 1'b0;
  logic [7:0]         fg_pix = '0, bg_pix = '0;
  logic               span_ready, stip_ready, wr_valid, span_done;
  logic               stip_valid = 1'b0;
  logic [31:0]        stip_data, wr_data;
  logic [ADDR_W-3:0]  wr_addr;
  logic [3:0]         wr_be;
  logic [31:0]        s0_q = '0, s1_q = '0;
  int                 beat_idx = 0;

  assign stip_data = (beat_idx == 0) ? s0_q : s1_q;

  stip_span_painter #(.ADDR_W(ADDR_W), .WIDTH_W(WIDTH_W), .BEAT_W(BEAT_W), .PIX_W(PIX_W))
  i_stip_span_painter (
    .clk(clk), .rst(rst), .span_start(span_start), .span_addr(span_addr),
    .span_width(span_width), .span_opaque(span_opaque), .fg_pix(fg_pix),
    .bg_pix(bg_pix), .span_ready(span_ready), .stip_valid(stip_valid),
    .stip_data(stip_data), .stip_ready(stip_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data), .span_done(span_done)
  );

  int n_checks = 0, n_fail = 0, last_iters = 0;
  logic [7:0] mem [128];
  logic [7:0] expm[128];

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic bit sbit(input logic [31:0] a, input logic [31:0] b, input int j);
    if (j < 32) return a[j];
    return b[j-32];
  endfunction

  function automatic bit legal(input logic [3:0] m);
    logic [4:0] low, s;
    low = {1'b0, m} & (~{1'b0, m} + 5'd1);
    s   = {1'b0, m} + low;
    return (m != 0) && ((s & {1'b0, m}) == 0) && ($countones(m) == 1 || m[0] || m[3]);
  endfunction

  function automatic int cost(input logic [3:0] m);
    if (m == 0) return 0;
    return legal(m) ? 1 : 2;
  endfunction

  task automatic run_span(input int addr, input int w, input bit op, input logic [31:0] s0,
                          input logic [31:0] s1, input logic [7:0] fg, input logic [7:0] bg,
                          input bit poke);
    int nwr = 0, nbeat = 0, ndone = 0, bad_be = 0, bad_dat = 0, stray = 0;
    int exp_wr = 0, iters = 0, mism = 0, extra = 0;
    bit inc = 0;
    string md;
    md = op ? "R3" : "R2";
    for (int i = 0; i < 128; i++) begin mem[i] = 8'(i); expm[i] = 8'(i); end
    for (int p = 0; p < w; p++) begin
      if (op) expm[addr+p] = sbit(s0, s1, p) ? fg : bg;
      else if (sbit(s0, s1, p)) expm[addr+p] = fg;
    end
    if (w > 0) begin
      for (int k = addr >> 2; k <= (addr + w - 1) >> 2; k++) begin
        logic [3:0] m;
        m = '0;
        for (int l = 0; l < 4; l++) begin
          int px;
          px = 4*k + l;
          if (px >= addr && px < addr + w && (op || sbit(s0, s1, px - addr))) m[l] = 1'b1;
        end
        exp_wr += op ? 1 : cost(m);
      end
    end
    @(negedge clk);
    s0_q = s0; s1_q = s1; beat_idx = 0;
    span_addr = ADDR_W'(addr); span_width = WIDTH_W'(w); span_opaque = op;
    fg_pix = fg; bg_pix = bg; span_start = 1'b1; stip_valid = 1'b1;
    while (ndone == 0 && iters < 400) begin
      @(posedge clk); #1;
      if (inc) beat_idx++;
      inc = 0;
      if (iters == 0) span_start = 1'b0;
      if (poke && iters == 2) begin
        span_start = 1'b1; span_addr = 100; span_width = 8; span_opaque = 1'b1;
      end else if (poke && iters == 3) span_start = 1'b0;
      @(negedge clk);
      iters++;
      if (wr_valid) begin
        nwr++;
        for (int l = 0; l < 4; l++) begin
          if (wr_be[l]) begin
            int idx;
            idx = int'(wr_addr) * 4 + l;
            if (idx < 128) mem[idx] = wr_data[l*8 +: 8];
            else stray++;
          end
        end
        if (!op) begin
          if (!legal(wr_be)) bad_be++;
          if (wr_data != {4{fg}}) bad_dat++;
        end
      end
      if (stip_ready) begin inc = 1; nbeat++; end
      if (span_done) ndone++;
    end
    stip_valid = 1'b0;
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      if (wr_valid || span_done) extra++;
    end
    last_iters = iters;
    for (int i = 0; i < 128; i++) if (mem[i] !== expm[i]) mism++;
    check(mism == 0, {md, "/R4/R5/R8 memory image"}, mism, 0);
    check(nwr == exp_wr, op ? "R7 write count" : "R6 write count", nwr, exp_wr);
    check(nbeat == (w + 31) / 32, "R13 beats taken", nbeat, (w + 31) / 32);
    check(ndone == 1 && extra == 0, "R11 single done pulse", ndone + extra, 1);
    check(span_ready == 1'b1, "R11 ready after done", span_ready, 1);
    check(stray == 0, "R5 writes outside region", stray, 0);
    if (!op) begin
      check(bad_be == 0, "R6 legal enables", bad_be, 0);
      check(bad_dat == 0, "R10 foreground in all lanes", bad_dat, 0);
    end
  endtask

  typedef struct packed {
    logic [7:0]  addr;
    logic [11:0] w;
    logic        op;
    logic [31:0] s0;
    logic [31:0] s1;
  } vec_t;

  localparam vec_t VECS[12] = '{
    '{8'd0,  12'd32, 1'b0, 32'hA5A50F3C, 32'h00000000},
    '{8'd1,  12'd20, 1'b0, 32'h000FFFF6, 32'h00000000},
    '{8'd2,  12'd45, 1'b1, 32'h12345678, 32'h00001ABC},
    '{8'd3,  12'd3,  1'b1, 32'h00000005, 32'h00000000},
    '{8'd5,  12'd2,  1'b1, 32'h00000002, 32'h00000000},
    '{8'd6,  12'd1,  1'b0, 32'h00000001, 32'h00000000},
    '{8'd4,  12'd64, 1'b0, 32'hFFFFFFFF, 32'h80000001},
    '{8'd9,  12'd40, 1'b0, 32'h00000000, 32'h00000000},
    '{8'd7,  12'd33, 1'b1, 32'h00000000, 32'hFFFFFFFF},
    '{8'd12, 12'd16, 1'b0, 32'h69699696, 32'h00000000},
    '{8'd2,  12'd2,  1'b0, 32'h00000003, 32'h00000000},
    '{8'd1,  12'd2,  1'b0, 32'h00000003, 32'h00000000}
  };

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    check(span_ready == 1'b1, "R1 ready after reset", span_ready, 1);
    check(wr_valid == 1'b0 && span_done == 1'b0, "R1 no write or done", {wr_valid, span_done}, 0);
    check(stip_ready == 1'b0, "R1 no beat request", stip_ready, 0);

    for (int v = 0; v < 12; v++) begin
      run_span(int'(VECS[v].addr), int'(VECS[v].w), VECS[v].op, VECS[v].s0, VECS[v].s1,
               8'hF0 | 8'(v), 8'hE0 | 8'(v), 1'b0);
    end

    // R9: a lone leading bit finishes right after its write
    run_span(0, 32, 1'b0, 32'h00000001, 32'h0, 8'hC5, 8'hD5, 1'b0);
    check(last_iters <= 3, "R9 early finish cycles", last_iters, 3);

    // R12: zero width
    run_span(5, 0, 1'b1, 32'hFFFFFFFF, 32'h0, 8'hC6, 8'hD6, 1'b0);
    check(last_iters == 1, "R12 zero width done", last_iters, 1);

    // R11: start while busy is ignored
    run_span(2, 64, 1'b1, 32'h0F0F3355, 32'hC3C3AA00, 8'hC7, 8'hD7, 1'b1);

    // R1: reset in mid-span returns to idle
    @(negedge clk);
    s0_q = 32'hFFFFFFFF; beat_idx = 0; stip_valid = 1'b1;
    span_addr = 0; span_width = 40; span_opaque = 1'b1; span_start = 1'b1;
    @(negedge clk); span_start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0; stip_valid = 1'b0;
    @(negedge clk);
    check(span_ready == 1'b1 && wr_valid == 1'b0 && span_done == 1'b0,
          "R1 idle after mid-span reset", {span_ready, wr_valid, span_done}, 3'b100);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule